// File: doc/BRIEF.md
# Even-Step Three-Bit Counter

A synchronous counter of three state bits that walks only through the even codes
000, 010, 100 and 110 and then wraps back to 000. Each enabled clock adds two to
the value. Every state bit sits in a different kind of storage element, each with
its own excitation logic. The low bit is a data flip-flop, the middle bit a
set/reset flip-flop, and the high bit a toggle-capable J/K flip-flop.

The excitation signals of the three stages are brought out as ports so that a
neighbour or a bench can watch them. A synchronous preset path loads any code,
odd ones included, into the stages. An odd code is never part of the counting
cycle. Once it is loaded, the low stage clears it at the next edge, so the
counter returns to the even set within one clock.

Top module: `evenstep_counter`

## Requirements
- R1: A synchronous active-high `rst` drives `count` to 000 at the next rising edge, whatever `en`, `preset_en` and `preset_val` are.
- R2: With `rst` and `preset_en` low, `en` high and an even `count`, each rising edge adds 2 modulo 8, giving the sequence 000, 010, 100, 110.
- R3: With `en` high, the code that follows 110 is 000.
- R4: With `rst`, `preset_en` and `en` low and an even `count`, `count` holds its value across clock edges.
- R5: The middle-stage excitation follows `s_mid = en & ~count[1]` and `r_mid = en & count[1]`, so the two are never both 1.
- R6: With `rst` and `preset_en` low, bit 0 of `count` is 0 after every edge. From an odd code with `en` high, the next code is the code with bit 0 cleared, plus 2, modulo 8 (011 goes to 100, 111 to 000). With `en` low, only bit 0 clears.
- R7: With `rst` low and `preset_en` high, `count` takes `preset_val` at the next edge, whatever `en` is.
- R8: The top-stage excitation follows `j_top = k_top = en & count[1]`, and the low-stage input `d_low` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable |
| preset_en | input | 1 | Load `preset_val` into the stages |
| preset_val | input | 3 | Code to load |
| count | output | 3 | Counter value |
| d_low | output | 1 | Data input of the bit-0 stage |
| s_mid | output | 1 | Set input of the bit-1 stage |
| r_mid | output | 1 | Reset input of the bit-1 stage |
| j_top | output | 1 | J input of the bit-2 stage |
| k_top | output | 1 | K input of the bit-2 stage |

## Verification
The step and hold properties assume that `count` is even at the sampling edge and that no preset is being applied. The odd-code property assumes only that no preset is in flight. The bench places odd codes only through `preset_en` and then releases the preset, so every property sees the inputs it expects. The preset path is the only way the stimulus reaches the don't-care codes. Reset is applied together with an active preset and enable to exercise the priority order of R1.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int CNT_W = 3;
    localparam int STEP  = 2;

    typedef struct packed {
        logic top;
        logic mid;
        logic low;
    } cnt_t;

    typedef struct packed {
        logic d_low;
        logic s_mid;
        logic r_mid;
        logic j_top;
        logic k_top;
    } exc_t;

    function automatic exc_t derive_exc(input cnt_t cur, input logic enable);
        exc_t e;
        e.d_low = 1'b0;
        e.s_mid = enable & ~cur.mid;
        e.r_mid = enable &  cur.mid;
        e.j_top = enable &  cur.mid;
        e.k_top = enable &  cur.mid;
        return e;
    endfunction
endpackage

// File: rtl/evc_excite.sv
module evc_excite
    import evc_pkg::*;
(
    input  cnt_t cur,
    input  logic enable,
    output exc_t exc
);
    always_comb exc = derive_exc(cur, enable);
endmodule

// File: rtl/evc_dff.sv
module evc_dff (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic ld_d,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (ld) q <= ld_d;
        else         q <= d;
    end
endmodule

// File: rtl/evc_srff.sv
module evc_srff (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic ld_d,
    input  logic s,
    input  logic r,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (ld) q <= ld_d;
        else begin
            case ({s, r})
                2'b10:   q <= 1'b1;
                2'b01:   q <= 1'b0;
                default: q <= q;
            endcase
        end
    end

    // R5: set and reset are never requested together
    a_r5_sr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(s && r));
endmodule

// File: rtl/evc_jkff.sv
module evc_jkff (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    input  logic ld_d,
    input  logic j,
    input  logic k,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (ld) q <= ld_d;
        else begin
            case ({j, k})
                2'b10:   q <= 1'b1;
                2'b01:   q <= 1'b0;
                2'b11:   q <= ~q;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/evenstep_counter.sv
module evenstep_counter
    import evc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             preset_en,
    input  logic [CNT_W-1:0] preset_val,
    output logic [CNT_W-1:0] count,
    output logic             d_low,
    output logic             s_mid,
    output logic             r_mid,
    output logic             j_top,
    output logic             k_top
);
    cnt_t st;
    cnt_t pre;
    exc_t exc;

    assign pre = cnt_t'(preset_val);

    evc_excite u_excite (
        .cur    (st),
        .enable (en),
        .exc    (exc)
    );

    evc_dff u_low (
        .clk  (clk),
        .rst  (rst),
        .ld   (preset_en),
        .ld_d (pre.low),
        .d    (exc.d_low),
        .q    (st.low)
    );

    evc_srff u_mid (
        .clk  (clk),
        .rst  (rst),
        .ld   (preset_en),
        .ld_d (pre.mid),
        .s    (exc.s_mid),
        .r    (exc.r_mid),
        .q    (st.mid)
    );

    evc_jkff u_top (
        .clk  (clk),
        .rst  (rst),
        .ld   (preset_en),
        .ld_d (pre.top),
        .j    (exc.j_top),
        .k    (exc.k_top),
        .q    (st.top)
    );

    assign count = st;
    assign d_low = exc.d_low;
    assign s_mid = exc.s_mid;
    assign r_mid = exc.r_mid;
    assign j_top = exc.j_top;
    assign k_top = exc.k_top;

    // R1: reset clears the count at the next edge
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> count == '0);

    // R2: enabled step from an even code advances by STEP
    a_r2_step_by_two: assert property (@(posedge clk) disable iff (rst)
        (en && !preset_en && !count[0]) |=> count == CNT_W'($past(count) + CNT_W'(STEP)));

    // R4: disabled counter holds an even code
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !preset_en && !count[0]) |=> $stable(count));

    // R6: bit 0 is cleared after any edge without a preset
    a_r6_odd_recovers: assert property (@(posedge clk) disable iff (rst)
        !preset_en |=> !count[0]);

    // R7: preset loads its value
    a_r7_preset_loads: assert property (@(posedge clk) disable iff (rst)
        preset_en |=> count == $past(preset_val));
endmodule

// File: tb/evenstep_counter_tb.sv
module evenstep_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       preset_en = 1'b0;
    logic [2:0] preset_val = 3'd0;
    logic [2:0] count;
    logic       d_low, s_mid, r_mid, j_top, k_top;

    int checks = 0;
    int errors = 0;
    logic [2:0] model = 3'd0;
    logic       model_ok = 1'b0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    evenstep_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .preset_en  (preset_en),
        .preset_val (preset_val),
        .count      (count),
        .d_low      (d_low),
        .s_mid      (s_mid),
        .r_mid      (r_mid),
        .j_top      (j_top),
        .k_top      (k_top)
    );

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic e, input logic p,
                         input logic [2:0] v, input string tag);
        logic [2:0] nxt;
        @(negedge clk);
        rst = r; en = e; preset_en = p; preset_val = v;
        #1;
        if (model_ok) begin
            chk("R5 s_mid", {2'b0, s_mid}, {2'b0, e & ~model[1]});
            chk("R5 r_mid", {2'b0, r_mid}, {2'b0, e & model[1]});
            chk("R5 not both", {2'b0, s_mid & r_mid}, 3'd0);
            chk("R8 j_top", {2'b0, j_top}, {2'b0, e & model[1]});
            chk("R8 k_top", {2'b0, k_top}, {2'b0, e & model[1]});
            chk("R8 d_low", {2'b0, d_low}, 3'd0);
        end
        if (r)      nxt = 3'd0;
        else if (p) nxt = v;
        else if (e) nxt = {model[2:1] + 2'd1, 1'b0};
        else        nxt = {model[2:1], 1'b0};
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
        model = nxt;
        if (r) model_ok = 1'b1;
    endtask

    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) chk(tag_q.pop_front(), count, exp_q.pop_front());
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive(1, 0, 0, 3'd0, "R1 reset");
        drive(1, 0, 0, 3'd0, "R1 reset held");
        drive(0, 1, 0, 3'd0, "R2 000->010");
        drive(0, 1, 0, 3'd0, "R2 010->100");
        drive(0, 1, 0, 3'd0, "R2 100->110");
        drive(0, 1, 0, 3'd0, "R3 wrap 110->000");
        drive(0, 1, 0, 3'd0, "R2 000->010 again");
        drive(0, 0, 0, 3'd0, "R4 hold 010");
        drive(0, 0, 0, 3'd0, "R4 hold 010 again");
        drive(0, 1, 0, 3'd0, "R2 010->100");
        drive(0, 0, 1, 3'd5, "R7 preset 101");
        drive(0, 1, 0, 3'd0, "R6 101->110");
        drive(0, 1, 1, 3'd7, "R7 preset 111 over en");
        drive(0, 1, 0, 3'd0, "R6 111->000");
        drive(0, 0, 1, 3'd3, "R7 preset 011");
        drive(0, 0, 0, 3'd0, "R6 011 en low ->010");
        drive(0, 0, 1, 3'd3, "R7 preset 011 again");
        drive(0, 1, 0, 3'd0, "R6 011->100");
        drive(0, 1, 1, 3'd1, "R7 preset 001");
        drive(0, 1, 0, 3'd0, "R6 001->010");
        drive(0, 1, 1, 3'd6, "R7 preset 110");
        drive(0, 1, 0, 3'd0, "R3 wrap after preset");
        drive(1, 1, 1, 3'd6, "R1 reset over preset");
        drive(0, 1, 0, 3'd0, "R2 after reset");
        drive(0, 1, 0, 3'd0, "R2 step");
        drive(0, 0, 0, 3'd0, "R4 hold 100");
        drive(0, 1, 0, 3'd0, "R2 100->110");
        drive(0, 1, 0, 3'd0, "R3 wrap again");
        drive(0, 0, 0, 3'd0, "R4 hold 000");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule